// File: doc/BRIEF.md
# Branch Next-PC Unit with Delay Slots

This block resolves control transfers for a 32-bit in-order core. For every branch-class operation handed to it, it works out where fetch goes next, whether the transfer was taken, and whether the instruction after the branch still executes as a delay slot. It also produces the link-register write (value and enable) and the set or clear strobes for two status bits: interrupt enable and break-in-progress.

The issue stage presents one decoded operation per cycle on `valid_i`. The operation carries a kind code, a condition code and three modifier bits (absolute, link, delay). It also carries the current PC, operand A, which is the condition value or the return base, and a target operand taken from a register or an immediate. The results are registered and appear one cycle later, qualified by `valid_o`. Fetch redirection, flushing and the register file itself sit outside this block.

Top module: `bnpc_unit`

## Requirements
- R1: A jump (kind 0) with absolute=0 is taken and yields next PC = PC + target, with wrap-around modulo 2^32.
- R2: A jump with absolute=1 is taken and yields next PC = target.
- R3: A jump with link=1, and every break, asserts the link write and presents the pre-branch PC as link data. No other kind asserts the link write.
- R4: A conditional branch (kind 1) reads operand A as a signed value and tests it against zero. Condition codes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. When taken it is always relative (PC + target), and it ignores absolute and link.
- R5: A branch that is not taken yields next PC = PC + 4, with the delay-slot flag low.
- R6: The delay-slot flag is high only for a taken transfer. For jumps and conditionals it follows the delay bit.
- R7: Returns (kinds 2 plain, 3 interrupt, 4 break) are always taken, yield next PC = operand A + target, and always flag a delay slot whatever the delay bit says.
- R8: An interrupt return pulses the interrupt-enable set strobe. A break return pulses the break-in-progress clear strobe. No other kind drives either strobe.
- R9: A break (kind 5) jumps to the target absolutely, links, pulses the break-in-progress set strobe, and never flags a delay slot.
- R10: Results appear on the clock edge after `valid_i` is sampled high. In a cycle with `valid_o` low, the taken, delay, link-write and status strobes are all low.
- R11: While reset is held, every output is zero.
- R12: Kind codes 6 and 7, and condition codes 6 and 7, are never taken. They yield next PC = PC + 4 with no link write and no status strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| kind_i | input | 3 | Operation kind: 0 jump, 1 conditional, 2 return, 3 interrupt return, 4 break return, 5 break |
| cond_i | input | 3 | Condition code for kind 1 |
| absolute_i | input | 1 | Jump target is absolute rather than PC-relative |
| link_i | input | 1 | Jump writes the link register |
| delay_i | input | 1 | Jump or conditional has a delay slot |
| pc_i | input | 32 | PC of the branch operation |
| opa_i | input | 32 | Operand A: condition value or return base |
| target_i | input | 32 | Target operand (register or immediate) |
| valid_o | output | 1 | Results valid |
| next_pc_o | output | 32 | Resolved next PC |
| taken_o | output | 1 | Transfer taken |
| delay_slot_o | output | 1 | Following instruction executes as delay slot |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | 32 | Link value (PC of the branch) |
| ie_set_o | output | 1 | Set interrupt-enable status bit |
| bip_set_o | output | 1 | Set break-in-progress status bit |
| bip_clr_o | output | 1 | Clear break-in-progress status bit |

## Verification
The bench builds the unit with its default 32-bit data width and a 4-byte instruction step. At that width the sign bit sits in bit 31, so the operand values 0x80000000 and 0xFFFFFFFF exercise the most-negative and minus-one corners of every condition. A PC of 0xFFFFFFFC makes the sequential step wrap to zero. Each condition code, including the two unused ones, is swept against zero, positive and negative operands with the delay, link and absolute bits all set. This shows that a not-taken branch keeps the delay flag low and that the conditionals ignore link and absolute.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [2:0] {
    KIND_JUMP    = 3'd0,
    KIND_COND    = 3'd1,
    KIND_RET     = 3'd2,
    KIND_RET_IRQ = 3'd3,
    KIND_RET_BRK = 3'd4,
    KIND_BREAK   = 3'd5
  } br_kind_e;

  typedef enum logic [2:0] {
    CC_EQ = 3'd0,
    CC_NE = 3'd1,
    CC_LT = 3'd2,
    CC_LE = 3'd3,
    CC_GT = 3'd4,
    CC_GE = 3'd5
  } br_cond_e;

  typedef enum logic [1:0] {
    TSEL_SEQ  = 2'd0,
    TSEL_REL  = 2'd1,
    TSEL_ABS  = 2'd2,
    TSEL_BASE = 2'd3
  } tgt_sel_e;

  typedef struct packed {
    logic taken;
    logic delay;
    logic link_we;
    logic ie_set;
    logic bip_set;
    logic bip_clr;
  } br_flags_t;

endpackage

// File: rtl/bnpc_cond_eval.sv
module bnpc_cond_eval #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa_i,
  input  logic [2:0]      cond_i,
  output logic            hit_o
);
  import bnpc_pkg::*;

  logic is_zero;
  logic is_neg;

  assign is_zero = (opa_i == '0);
  assign is_neg  = opa_i[XLEN-1];

  always_comb begin
    unique case (br_cond_e'(cond_i))
      CC_EQ:   hit_o = is_zero;
      CC_NE:   hit_o = !is_zero;
      CC_LT:   hit_o = is_neg;
      CC_LE:   hit_o = is_neg || is_zero;
      CC_GT:   hit_o = !is_neg && !is_zero;
      CC_GE:   hit_o = !is_neg;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_target_gen.sv
module bnpc_target_gen #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [1:0]      sel_i,
  output logic [XLEN-1:0] next_pc_o
);
  import bnpc_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] base_pc;

  assign seq_pc  = pc_i + STEP;
  assign rel_pc  = pc_i + target_i;
  assign base_pc = opa_i + target_i;

  always_comb begin
    unique case (tgt_sel_e'(sel_i))
      TSEL_REL:  next_pc_o = rel_pc;
      TSEL_ABS:  next_pc_o = target_i;
      TSEL_BASE: next_pc_o = base_pc;
      default:   next_pc_o = seq_pc;
    endcase
  end

endmodule

// File: rtl/bnpc_ctrl.sv
module bnpc_ctrl (
  input  logic                 kind_valid_i,
  input  logic [2:0]           kind_i,
  input  logic                 absolute_i,
  input  logic                 link_i,
  input  logic                 delay_i,
  input  logic                 cond_hit_i,
  output logic [1:0]           sel_o,
  output bnpc_pkg::br_flags_t  flags_o
);
  import bnpc_pkg::*;

  always_comb begin
    sel_o   = TSEL_SEQ;
    flags_o = '0;
    if (kind_valid_i) begin
      unique case (br_kind_e'(kind_i))
        KIND_JUMP: begin
          sel_o           = absolute_i ? TSEL_ABS : TSEL_REL;
          flags_o.taken   = 1'b1;
          flags_o.link_we = link_i;
          flags_o.delay   = delay_i;
        end
        KIND_COND: begin
          sel_o         = cond_hit_i ? TSEL_REL : TSEL_SEQ;
          flags_o.taken = cond_hit_i;
          flags_o.delay = cond_hit_i && delay_i;
        end
        KIND_RET, KIND_RET_IRQ, KIND_RET_BRK: begin
          sel_o           = TSEL_BASE;
          flags_o.taken   = 1'b1;
          flags_o.delay   = 1'b1;
          flags_o.ie_set  = (kind_i == KIND_RET_IRQ);
          flags_o.bip_clr = (kind_i == KIND_RET_BRK);
        end
        KIND_BREAK: begin
          sel_o           = TSEL_ABS;
          flags_o.taken   = 1'b1;
          flags_o.link_we = 1'b1;
          flags_o.bip_set = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      kind_i,
  input  logic [2:0]      cond_i,
  input  logic            absolute_i,
  input  logic            link_i,
  input  logic            delay_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] target_i,
  output logic            valid_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            delay_slot_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            ie_set_o,
  output logic            bip_set_o,
  output logic            bip_clr_o
);
  import bnpc_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            cond_hit;
  logic [1:0]      tgt_sel;
  br_flags_t       flags_d;
  br_flags_t       flags_q;
  logic [XLEN-1:0] next_pc_d;

  bnpc_cond_eval #(.XLEN(XLEN)) u_cond (
    .opa_i  (opa_i),
    .cond_i (cond_i),
    .hit_o  (cond_hit)
  );

  bnpc_ctrl u_ctrl (
    .kind_valid_i (valid_i),
    .kind_i       (kind_i),
    .absolute_i   (absolute_i),
    .link_i       (link_i),
    .delay_i      (delay_i),
    .cond_hit_i   (cond_hit),
    .sel_o        (tgt_sel),
    .flags_o      (flags_d)
  );

  bnpc_target_gen #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc_i      (pc_i),
    .opa_i     (opa_i),
    .target_i  (target_i),
    .sel_i     (tgt_sel),
    .next_pc_o (next_pc_d)
  );

  // result register: one operation per cycle, flags cleared when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      next_pc_o   <= '0;
      link_data_o <= '0;
      flags_q     <= '0;
    end else begin
      valid_o     <= valid_i;
      flags_q     <= flags_d;
      next_pc_o   <= valid_i ? next_pc_d : '0;
      link_data_o <= valid_i ? pc_i : '0;
    end
  end

  assign taken_o      = flags_q.taken;
  assign delay_slot_o = flags_q.delay;
  assign link_we_o    = flags_q.link_we;
  assign ie_set_o     = flags_q.ie_set;
  assign bip_set_o    = flags_q.bip_set;
  assign bip_clr_o    = flags_q.bip_clr;

  p_delay_only_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_slot_o |-> taken_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(taken_o || delay_slot_o || link_we_o || ie_set_o || bip_set_o || bip_clr_o));

  p_not_taken_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(rst_ni)) ##1 (valid_o && !taken_o) |-> next_pc_o == $past(pc_i) + STEP);

  p_link_is_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(rst_ni)) ##1 link_we_o |-> link_data_o == $past(pc_i));

  p_bip_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bip_set_o && bip_clr_o) && !(ie_set_o && (bip_set_o || bip_clr_o)));

  p_break_no_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_set_o |-> (!delay_slot_o && link_we_o && taken_o));

  p_return_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_set_o || bip_clr_o) |-> (delay_slot_o && taken_o && !link_we_o));

endmodule

// File: tb/bnpc_unit_tb_top.sv
`timescale 1ns/1ps
module bnpc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [2:0]  cond_i = '0;
  logic        absolute_i = 1'b0;
  logic        link_i = 1'b0;
  logic        delay_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] target_i = '0;
  logic        valid_o;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        delay_slot_o;
  logic        link_we_o;
  logic [31:0] link_data_o;
  logic        ie_set_o;
  logic        bip_set_o;
  logic        bip_clr_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  bnpc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .kind_i(kind_i), .cond_i(cond_i),
    .absolute_i(absolute_i), .link_i(link_i), .delay_i(delay_i), .pc_i(pc_i),
    .opa_i(opa_i), .target_i(target_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .delay_slot_o(delay_slot_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .ie_set_o(ie_set_o), .bip_set_o(bip_set_o),
    .bip_clr_o(bip_clr_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, result registered at the rising edge, sample on the next falling edge
  task automatic issue(input logic [2:0] k, input logic [2:0] c, input logic a, input logic l,
                       input logic d, input logic [31:0] pc, input logic [31:0] oa, input logic [31:0] t);
    @(negedge clk);
    valid_i = 1'b1; kind_i = k; cond_i = c; absolute_i = a; link_i = l; delay_i = d;
    pc_i = pc; opa_i = oa; target_i = t;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_all(input string req, input logic [31:0] npc, input logic tk, input logic dl,
                            input logic lw, input logic [31:0] ld, input logic ie, input logic bs, input logic bc);
    chk(req, "valid", {31'd0, valid_o}, 32'd1);
    chk(req, "next_pc", next_pc_o, npc);
    chk(req, "taken", {31'd0, taken_o}, {31'd0, tk});
    chk(req, "delay", {31'd0, delay_slot_o}, {31'd0, dl});
    chk(req, "link_we", {31'd0, link_we_o}, {31'd0, lw});
    if (lw) chk(req, "link_data", link_data_o, ld);
    chk(req, "ie_set", {31'd0, ie_set_o}, {31'd0, ie});
    chk(req, "bip_set", {31'd0, bip_set_o}, {31'd0, bs});
    chk(req, "bip_clr", {31'd0, bip_clr_o}, {31'd0, bc});
  endtask

  task automatic t_reset;  // R11
    chk("R11", "outputs", {valid_o, taken_o, delay_slot_o, link_we_o, ie_set_o, bip_set_o, bip_clr_o},
        32'd0);
    chk("R11", "next_pc", next_pc_o, 32'd0);
    chk("R11", "link_data", link_data_o, 32'd0);
  endtask

  task automatic t_jumps;
    issue(3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 32'h0, 32'h0000_0020);
    expect_all("R1", 32'h0000_1020, 1, 0, 0, 0, 0, 0, 0);
    issue(3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 32'h0, 32'hFFFF_FFF0);  // backward, wraps
    expect_all("R1", 32'h0000_0FF0, 1, 1, 0, 0, 0, 0, 0);
    issue(3'd0, 3'd0, 1'b1, 1'b1, 1'b1, 32'h0000_2000, 32'h0, 32'h0000_0400);
    expect_all("R2", 32'h0000_0400, 1, 1, 1, 32'h0000_2000, 0, 0, 0);
    issue(3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_3000, 32'h0, 32'h0000_0010);
    expect_all("R3", 32'h0000_3010, 1, 0, 1, 32'h0000_3000, 0, 0, 0);
  endtask

  task automatic t_conditions;  // R4 R5 R6 R12
    logic [31:0] vals [4];
    vals[0] = 32'h0; vals[1] = 32'h5; vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0000;
    for (int v = 0; v < 4; v++) begin
      for (int c = 0; c < 8; c++) begin
        logic hit;
        int sv;
        sv = $signed(vals[v]);
        case (c)
          0: hit = (sv == 0);
          1: hit = (sv != 0);
          2: hit = (sv < 0);
          3: hit = (sv <= 0);
          4: hit = (sv > 0);
          5: hit = (sv >= 0);
          default: hit = 1'b0;
        endcase
        issue(3'd1, 3'(c), 1'b1, 1'b1, 1'b1, 32'h0000_4000, vals[v], 32'h0000_0100);
        if (c > 5) expect_all("R12", 32'h0000_4004, 0, 0, 0, 0, 0, 0, 0);
        else if (hit) expect_all("R4", 32'h0000_4100, 1, 1, 0, 0, 0, 0, 0);
        else expect_all("R5", 32'h0000_4004, 0, 0, 0, 0, 0, 0, 0);
      end
    end
    issue(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFC, 32'h1, 32'h0000_0100);
    expect_all("R5", 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0);
    issue(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 32'h0, 32'h0000_0100);
    expect_all("R6", 32'h0000_4100, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_returns;  // R7 R8
    issue(3'd2, 3'd0, 1'b1, 1'b1, 1'b0, 32'h0000_9000, 32'h0000_4000, 32'h0000_0008);
    expect_all("R7", 32'h0000_4008, 1, 1, 0, 0, 0, 0, 0);
    issue(3'd3, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_9000, 32'h0000_5000, 32'h0000_0004);
    expect_all("R8", 32'h0000_5004, 1, 1, 0, 0, 1, 0, 0);
    issue(3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_9000, 32'h0000_6000, 32'h0000_000C);
    expect_all("R8", 32'h0000_600C, 1, 1, 0, 0, 0, 0, 1);
  endtask

  task automatic t_break;  // R9
    issue(3'd5, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0000_7000, 32'h0000_1234, 32'h0000_0018);
    expect_all("R9", 32'h0000_0018, 1, 0, 1, 32'h0000_7000, 0, 1, 0);
  endtask

  task automatic t_reserved;  // R12
    issue(3'd6, 3'd0, 1'b1, 1'b1, 1'b1, 32'h0000_8000, 32'h0, 32'h0000_0040);
    expect_all("R12", 32'h0000_8004, 0, 0, 0, 0, 0, 0, 0);
    issue(3'd7, 3'd0, 1'b0, 1'b1, 1'b1, 32'h0000_8000, 32'h0, 32'h0000_0040);
    expect_all("R12", 32'h0000_8004, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;  // R10
    issue(3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 32'h0, 32'h0000_0080);
    expect_all("R10", 32'h0000_0080, 1, 0, 1, 32'h0000_1000, 0, 1, 0);
    kind_i = 3'd5;  // valid_i already low; kind left at a break
    @(negedge clk);
    chk("R10", "idle flags", {valid_o, taken_o, delay_slot_o, link_we_o, ie_set_o, bip_set_o, bip_clr_o},
        32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_jumps();
    t_conditions();
    t_returns();
    t_break();
    t_reserved();
    t_idle();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule